// File: doc/BRIEF.md
# Full-Duplex Serial Port with Register Interface

This block is an asynchronous serial port with a transmitter and a receiver that run at the same time and do not depend on each other. Software reaches it through two byte-wide register addresses. The control/status address holds the mode, the receive enable, the ninth transmit bit and the status flags. The data address behaves differently for each access direction. A write loads the transmitter and starts a frame. A read returns the receive holding register. The transmitter's contents can never be read back.

Each bit lasts a fixed number of cycles of an external enable tick, which runs at sixteen times the bit rate. The block supports two frame formats. The first carries eight data bits. The second carries eight data bits and a ninth bit, which software supplies on transmit and the block captures on receive. A received byte moves from the 9-bit input shift register into a separate holding register, so the next frame can start arriving before software has read the last one. The transmit-done and receive-done flags stay set until software writes a zero to them. One level interrupt is asserted while either flag is set.

Top module: `uart_sfr`

## Requirements
- R1: `txd` idles high. A frame is one low start bit, then the data bits least significant first, then one high stop bit. Each bit lasts 16 `baud_tick` pulses.
- R2: When control bit 7 (mode) is 1, the frame carries a ninth bit after bit 7 of the data, and its value comes from control bit 3. When mode is 0, the frame has no ninth bit.
- R3: A write to the data address (`reg_sel`=1) starts a frame when no frame is in progress. A data write during a frame is ignored and the frame in progress continues unchanged. Control bit 5 reads 1 from the start of the frame until the transmit flag sets.
- R4: The transmit flag (control bit 1) sets when the stop bit ends. It stays set until software writes 0 to that bit. Writing 1 to it has no effect.
- R5: While the receive enable (control bit 4) is 1, a complete frame on `rxd` loads its byte into the holding register, which a read of the data address returns. The same frame sets the receive flag (control bit 0). Writing 0 to bit 0 clears the flag.
- R6: Control bit 2 captures the ninth received bit in mode 1 and the stop bit in mode 0.
- R7: The receiver checks the start bit half a bit time after the falling edge. If `rxd` is high at that point, it drops the frame.
- R8: When a frame completes while the receive flag is still set, the byte is discarded. The holding register and bit 2 keep their old values, and control bit 6 (overrun) sets. Writing 0 to bit 6 clears it.
- R9: `irq` is high exactly while the transmit flag or the receive flag is set.
- R10: A frame can be transmitted and another received over the same interval, and both are correct.
- R11: After reset, `txd` is 1, `irq` is 0, and both addresses read 0x00.
- R12: While the receive enable is 0, frames on `rxd` are ignored. The receive flag stays clear and the holding register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| reg_sel | input | 1 | Register address: 0 selects control/status, 1 selects data |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Level interrupt request |

## Verification
Several internal faults show up within one bit time as a wrong level on `txd`. These include a bit counter that is off by one, a mis-ordered shift and a dropped ninth bit. A busy state that clears too early shows up in the same frame, through the busy bit and a corrupted frame after a second data write. Receive faults appear within one frame time: the holding register, the ninth-bit field, the overrun bit and `irq` read back wrong. A broken start-bit check sets the receive flag after a glitch that it should have rejected.

// File: rtl/uart_sfr_pkg.sv
package uart_sfr_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 8;

  localparam int CB_MODE = 7;
  localparam int CB_OVR  = 6;
  localparam int CB_BUSY = 5;
  localparam int CB_REN  = 4;
  localparam int CB_TB8  = 3;
  localparam int CB_RB8  = 2;
  localparam int CB_TI   = 1;
  localparam int CB_RI   = 0;

  // total bits on the line for one frame: start + data + optional ninth + stop
  function automatic int unsigned frame_bits(input logic nine, input int unsigned dw);
    return dw + 2 + (nine ? 1 : 0);
  endfunction

  // bits the receiver shifts after the start bit (data + optional ninth + stop)
  function automatic int unsigned rx_bits(input logic nine, input int unsigned dw);
    return dw + 1 + (nine ? 1 : 0);
  endfunction

  // tick index at which the start bit is checked (centre of the bit)
  function automatic int unsigned mid_tick(input int unsigned osr);
    return osr / 2 - 1;
  endfunction
endpackage

// File: rtl/uart_tx.sv
module uart_tx
  import uart_sfr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          nine,
  input  logic          ninth,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] left_q;
  logic          act_q;
  logic          bit_end;

  assign bit_end = act_q && tick && (cnt_q == CW'(OSR - 1));
  assign done    = bit_end && (left_q == BW'(1));
  assign txd     = act_q ? sh_q[0] : 1'b1;
  assign busy    = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
    end else if (load && !act_q) begin
      sh_q   <= {1'b1, (nine ? ninth : 1'b1), data, 1'b0};
      cnt_q  <= '0;
      left_q <= BW'(frame_bits(nine, DW));
      act_q  <= 1'b1;
    end else if (act_q && tick) begin
      if (bit_end) begin
        cnt_q  <= '0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - BW'(1);
        if (left_q == BW'(1)) act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_sfr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_e;

  rx_state_e     st_q;
  logic [1:0]    sync_q;
  logic          rx_s;
  logic [DW:0]   sh_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] left_q;
  logic          nine_q;
  logic          bit_end;

  assign rx_s    = sync_q[1];
  assign bit_end = tick && (cnt_q == CW'(OSR - 1));
  assign done    = en && (st_q == S_BITS) && bit_end && (left_q == BW'(1));
  assign data    = nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
  assign bit9    = nine_q ? sh_q[DW] : rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      nine_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (en && !rx_s) begin
            st_q   <= S_START;
            cnt_q  <= '0;
            nine_q <= nine;
          end
        end
        S_START: begin
          if (!en) begin
            st_q <= S_IDLE;
          end else if (tick) begin
            if (cnt_q == CW'(mid_tick(OSR))) begin
              cnt_q <= '0;
              if (rx_s) begin
                st_q <= S_IDLE;
              end else begin
                st_q   <= S_BITS;
                left_q <= BW'(rx_bits(nine_q, DW));
              end
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        S_BITS: begin
          if (!en) begin
            st_q <= S_IDLE;
          end else if (tick) begin
            if (bit_end) begin
              cnt_q <= '0;
              if (left_q == BW'(1)) begin
                st_q <= S_IDLE;
              end else begin
                sh_q   <= {rx_s, sh_q[DW:1]};
                left_q <= left_q - BW'(1);
              end
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_sfr.sv
module uart_sfr
  import uart_sfr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             irq
);
  logic              mode_q, ren_q, tb8_q, rb8_q, ti_q, ri_q, ovr_q;
  logic [DATA_W-1:0] rbuf_q;

  // named internal events
  logic              wr_ctl, wr_dat;
  logic              tx_start, tx_busy, tx_done;
  logic              rx_done, rx_b9, rx_load, rx_ovr_evt;
  logic [DATA_W-1:0] rx_data;
  logic [REG_W-1:0]  ctl_view;

  assign wr_ctl     = reg_we && !reg_sel;
  assign wr_dat     = reg_we && reg_sel;
  assign tx_start   = wr_dat && !tx_busy;
  assign rx_load    = rx_done && !ri_q;
  assign rx_ovr_evt = rx_done && ri_q;

  uart_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .load  (tx_start),
    .nine  (mode_q),
    .ninth (tb8_q),
    .data  (reg_wdata[DATA_W-1:0]),
    .txd   (txd),
    .busy  (tx_busy),
    .done  (tx_done)
  );

  uart_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .en    (ren_q),
    .nine  (mode_q),
    .rxd   (rxd),
    .done  (rx_done),
    .data  (rx_data),
    .bit9  (rx_b9)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ren_q  <= 1'b0;
      tb8_q  <= 1'b0;
    end else if (wr_ctl) begin
      mode_q <= reg_wdata[CB_MODE];
      ren_q  <= reg_wdata[CB_REN];
      tb8_q  <= reg_wdata[CB_TB8];
    end
  end

  // status flags: hardware set wins; software may only clear by writing 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_q  <= 1'b0;
      ri_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (tx_done)                           ti_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[CB_TI])  ti_q <= 1'b0;
      if (rx_load)                           ri_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[CB_RI])  ri_q <= 1'b0;
      if (rx_ovr_evt)                        ovr_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[CB_OVR]) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      rb8_q  <= 1'b0;
    end else if (rx_load) begin
      rbuf_q <= rx_data;
      rb8_q  <= rx_b9;
    end
  end

  always_comb begin
    ctl_view          = '0;
    ctl_view[CB_MODE] = mode_q;
    ctl_view[CB_OVR]  = ovr_q;
    ctl_view[CB_BUSY] = tx_busy;
    ctl_view[CB_REN]  = ren_q;
    ctl_view[CB_TB8]  = tb8_q;
    ctl_view[CB_RB8]  = rb8_q;
    ctl_view[CB_TI]   = ti_q;
    ctl_view[CB_RI]   = ri_q;
  end

  assign reg_rdata = reg_sel ? REG_W'(rbuf_q) : ctl_view;
  assign irq       = ti_q | ri_q;
endmodule

// File: rtl/uart_sfr_chk.sv
module uart_sfr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       irq,
  input logic       tx_busy,
  input logic       tx_start,
  input logic       tx_done,
  input logic       rx_done,
  input logic       ri_q,
  input logic       ti_q,
  input logic       ovr_q,
  input logic [7:0] rbuf_q,
  input logic [7:0] rx_data
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> tx_busy);

  a_r4_ti_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (ti_q && !tx_busy));

  a_r5_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !ri_q) |=> (ri_q && rbuf_q == $past(rx_data)));

  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && ri_q) |=> (ovr_q && $stable(rbuf_q)));

  a_r9_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_done) |=> irq);
endmodule

bind uart_sfr uart_sfr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .txd      (txd),
  .irq      (irq),
  .tx_busy  (tx_busy),
  .tx_start (tx_start),
  .tx_done  (tx_done),
  .rx_done  (rx_done),
  .ri_q     (ri_q),
  .ti_q     (ti_q),
  .ovr_q    (ovr_q),
  .rbuf_q   (rbuf_q),
  .rx_data  (rx_data)
);

// File: tb/uart_sfr_tb.sv
`timescale 1ns/1ps
module uart_sfr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  uart_sfr u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  // {mid-frame write, mode, ninth bit, data}
  localparam logic [10:0] TXV [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'h01},
    {1'b1, 1'b0, 1'b0, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'hFF},
    {1'b1, 1'b1, 1'b1, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // callers sit just after a falling edge; one cycle per write
  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  // control value: flag bits written 1 keep their state
  function automatic logic [7:0] ctl(input logic mode, input logic ren, input logic tb8,
                                     input logic keep_ovr, input logic keep_ti,
                                     input logic keep_ri);
    return {mode, keep_ovr, 1'b0, ren, tb8, 1'b0, keep_ti, keep_ri};
  endfunction

  task automatic tx_frame(input logic mid, input logic mode, input logic tb8,
                          input logic ren, input logic [7:0] d);
    logic [7:0] v;
    logic [10:0] bits;
    int n;
    bits = {1'b1, tb8, d, 1'b0};
    n = mode ? 11 : 10;
    if (!mode) bits[9] = 1'b1;
    wr(1'b0, ctl(mode, ren, tb8, 1'b1, 1'b1, 1'b1));
    wr(1'b1, d);
    repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk(mode ? "R2 R1 tx bit" : "R1 tx bit", {7'd0, txd}, {7'd0, bits[k]});
      if (k == 0) begin
        rd(1'b0, v);
        chk("R3 busy during frame", {7'd0, v[5]}, 8'd1);
      end
      if (k < n - 1) begin
        if (mid && k == 3) begin
          wr(1'b1, ~d);
          repeat (15) @(negedge clk);
        end else begin
          repeat (16) @(negedge clk);
        end
      end
    end
    repeat (9) @(negedge clk);
    rd(1'b0, v);
    chk("R4 TI after stop", {7'd0, v[1]}, 8'd1);
    chk("R3 busy clear at TI", {7'd0, v[5]}, 8'd0);
    chk("R1 idle high", {7'd0, txd}, 8'd1);
    wr(1'b0, ctl(mode, ren, tb8, 1'b1, 1'b0, 1'b1));
    rd(1'b0, v);
    chk("R4 TI cleared by write 0", {7'd0, v[1]}, 8'd0);
  endtask

  task automatic rx_frame(input logic nine, input logic [7:0] d, input logic b9,
                          input logic stopb);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (16) @(negedge clk);
    end
    rxd = stopb;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    rd(1'b0, v); chk("R11 control after reset", v, 8'h00);
    rd(1'b1, v); chk("R11 data after reset", v, 8'h00);
    chk("R11 txd after reset", {7'd0, txd}, 8'd1);
    chk("R11 irq after reset", {7'd0, irq}, 8'd0);

    // transmit vectors: R1, R2, R3 (mid-frame writes), R4
    for (int t = 0; t < 6; t++) begin
      tx_frame(TXV[t][10], TXV[t][9], TXV[t][8], 1'b0, TXV[t][7:0]);
    end

    // R9: TI drives irq
    wr(1'b0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    wr(1'b1, 8'h55);
    repeat (170) @(negedge clk);
    chk("R9 irq from TI", {7'd0, irq}, 8'd1);
    wr(1'b0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
    chk("R9 irq low after TI clear", {7'd0, irq}, 8'd0);

    // R5/R6: 8-bit receive, RB8 takes the stop bit
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    rx_frame(1'b0, 8'hA5, 1'b0, 1'b1);
    rd(1'b1, v); chk("R5 received byte", v, 8'hA5);
    rd(1'b0, v);
    chk("R5 RI set", {7'd0, v[0]}, 8'd1);
    chk("R6 RB8 is stop bit", {7'd0, v[2]}, 8'd1);
    chk("R9 irq from RI", {7'd0, irq}, 8'd1);

    // R8: overrun while RI set
    rx_frame(1'b0, 8'h3C, 1'b0, 1'b0);
    rd(1'b1, v); chk("R8 buffer kept on overrun", v, 8'hA5);
    rd(1'b0, v);
    chk("R8 overrun set", {7'd0, v[6]}, 8'd1);
    chk("R8 RB8 kept on overrun", {7'd0, v[2]}, 8'd1);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    rd(1'b0, v);
    chk("R5 RI cleared by write 0", {7'd0, v[0]}, 8'd0);
    chk("R8 overrun survives RI clear", {7'd0, v[6]}, 8'd1);
    chk("R9 irq low with no flag", {7'd0, irq}, 8'd0);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    rd(1'b0, v);
    chk("R8 overrun cleared by write 0", {7'd0, v[6]}, 8'd0);

    // R6: 9-bit receive
    wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    rx_frame(1'b1, 8'h5A, 1'b0, 1'b1);
    rd(1'b1, v); chk("R6 9-bit byte", v, 8'h5A);
    rd(1'b0, v);
    chk("R6 RB8 ninth bit 0", {7'd0, v[2]}, 8'd0);
    wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    rx_frame(1'b1, 8'hC3, 1'b1, 1'b1);
    rd(1'b1, v); chk("R6 9-bit byte second", v, 8'hC3);
    rd(1'b0, v);
    chk("R6 RB8 ninth bit 1", {7'd0, v[2]}, 8'd1);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));

    // R7: short low glitch rejected
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(1'b0, v); chk("R7 glitch sets no RI", {7'd0, v[0]}, 8'd0);
    rd(1'b1, v); chk("R7 buffer unchanged", v, 8'hC3);

    // R12: receiver disabled
    wr(1'b0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    rx_frame(1'b0, 8'h77, 1'b0, 1'b1);
    rd(1'b0, v); chk("R12 RI stays clear", {7'd0, v[0]}, 8'd0);
    rd(1'b1, v); chk("R12 buffer unchanged", v, 8'hC3);

    // R10: transmit and receive at once
    fork
      tx_frame(1'b0, 1'b0, 1'b0, 1'b1, 8'h69);
      begin
        repeat (5) @(negedge clk);
        rx_frame(1'b0, 8'h96, 1'b0, 1'b1);
      end
    join
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk("R10 byte received during transmit", v, 8'h96);
    rd(1'b0, v); chk("R10 RI set", {7'd0, v[0]}, 8'd1);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule